// File: doc/BRIEF.md
# Indexed RTC Register File

This block holds the 128 byte registers of a real-time-clock and configuration store behind a two-port bus. It has an index port and a data port. Software first writes a register number to the index port. It then reads or writes that register through the data port.

The block applies the side effects that belong to each register:
- The interrupt-flag register clears itself when it is read.
- Two status registers cannot be written.
- The top bit of the first control register is a busy flag, and only the time-keeping logic drives it.
- The second control register drops some bit combinations on write.
- One century byte mirrors writes into the other.
- A 16-bit sum over the configuration bytes can be read at two fixed indices.

The block publishes the control-register fields and an interrupt request as ports. The time-keeping logic next to it reports its events and its busy state on inputs. Reset comes in two forms. A cold reset (`cold_rst` high while `rst_n` is low) loads the power-up contents. A warm reset changes only the index and a few control bits.

Top module: `rtc_regfile`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata[6:0]` as the register index, so bit 7 of the written byte is dropped.
- R2: A read with `bus_sel`=0 returns 0xFF.
- R3: A data read of index 0x0C returns the flag byte as it stood before the read. The read clears the byte, and `irq` falls unless an event arrives in the same cycle. `irq_clr` pulses for one cycle together with the read data.
- R4: An event input sets its flag bit in register 0x0C only while its enable bit in register 0x0B is set. The pairs are: `evt_periodic` sets bit 6 when enable bit 6 is set, `evt_alarm` sets bit 5 when enable bit 5 is set, and `evt_update` sets bit 4 when enable bit 4 is set. Any flag that is set also sets bit 7, which drives `irq`. An event that arrives in the same cycle as a read of 0x0C is kept.
- R5: Data writes to index 0x0C and to index 0x0D change nothing.
- R6: A data write to index 0x0A changes only bits 6:0. Bit 7 reads as `upd_busy`, registered once.
- R7: A data write to index 0x0B stores the byte with bit 3 cleared. When bit 7 of the written byte is 1, bit 4 is also cleared.
- R8: A data write to index 0x37 stores the byte at both 0x37 and 0x32. A write to 0x32 leaves 0x37 unchanged.
- R9: A warm reset sets the index to 0, clears bits 6:4 of 0x0B, and clears 0x0C. It keeps 0x0A, 0x0D and all other bytes.
- R10: A cold reset loads 0x26 into 0x0A, 0x02 into 0x0B, 0x00 into 0x0C and 0x80 into 0x0D, and zero into every other byte.
- R11: Index 0x2E reads the high byte and index 0x2F the low byte of the 16-bit sum of bytes 0x10 to 0x2D. Data writes to these two indices are ignored.
- R12: Read data is registered. It appears in the cycle after the read strobe and holds until the next read. When `bus_rd` and `bus_wr` are both high, the access is a write only and has no read side effects.
- R13: The control fields are ports:
  - `rate_sel` = 0x0A[3:0] and `div_ctl` = 0x0A[6:4].
  - `dst_en`, `hour24`, `bin_mode`, `upd_ie`, `alm_ie`, `per_ie` and `set_mode` = 0x0B bits 0, 1, 2, 4, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cold_rst | input | 1 | High during reset selects the power-up contents |
| bus_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| upd_busy | input | 1 | Update-in-progress level from the time-keeping logic |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| irq | output | 1 | Interrupt request (flag byte bit 7) |
| irq_clr | output | 1 | One-cycle pulse after a read of the flag byte |
| rate_sel | output | 4 | Periodic rate select field |
| div_ctl | output | 3 | Divider control field |
| dst_en | output | 1 | Daylight-saving enable |
| hour24 | output | 1 | 24-hour format |
| bin_mode | output | 1 | Binary data format |
| upd_ie | output | 1 | Update-ended interrupt enable |
| alm_ie | output | 1 | Alarm interrupt enable |
| per_ie | output | 1 | Periodic interrupt enable |
| set_mode | output | 1 | Update-freeze mode |

## Verification
The clear-on-read of the flag byte and the setting of a flag by an event can fall on the same clock edge. If the clear wins, the event is lost. The bench raises `evt_periodic` in the same cycle as a data read of 0x0C. It then expects three things: the read returns the old flags, `irq` stays high, and the next read returns the new periodic flag. It also overlaps a read strobe with a write strobe. In that case it expects the read data to hold and the flags to survive.

// File: rtl/rtc_regfile_pkg.sv
// Shared constants and types for the indexed RTC register file.
// Assumes an 8-bit data path and a 7-bit register index.
package rtc_regfile_pkg;

    localparam int IDX_W = 7;
    localparam int DW    = 8;
    localparam int SUM_W = 16;
    localparam int NREG  = 1 << IDX_W;

    // Indices with special behaviour
    localparam logic [IDX_W-1:0] IX_CTL_A     = 7'h0A;
    localparam logic [IDX_W-1:0] IX_CTL_B     = 7'h0B;
    localparam logic [IDX_W-1:0] IX_FLAGS     = 7'h0C;
    localparam logic [IDX_W-1:0] IX_STAT_D    = 7'h0D;
    localparam logic [IDX_W-1:0] IX_SUM_FIRST = 7'h10;
    localparam logic [IDX_W-1:0] IX_SUM_LAST  = 7'h2D;
    localparam logic [IDX_W-1:0] IX_SUM_HI    = 7'h2E;
    localparam logic [IDX_W-1:0] IX_SUM_LO    = 7'h2F;
    localparam logic [IDX_W-1:0] IX_CENT      = 7'h32;
    localparam logic [IDX_W-1:0] IX_CENT_ALT  = 7'h37;

    localparam int SUM_N = int'(IX_SUM_LAST) - int'(IX_SUM_FIRST) + 1;

    // Cold-reset contents of the control bytes
    localparam logic [DW-1:0] COLD_A = 8'h26;
    localparam logic [DW-1:0] COLD_B = 8'h02;
    localparam logic [DW-1:0] COLD_D = 8'h80;
    // Bits of control B that survive a warm reset
    localparam logic [DW-1:0] WARM_B_KEEP = 8'h8F;

    // Which logic owns a register index
    typedef enum logic [2:0] {
        OWN_MEM,
        OWN_A,
        OWN_B,
        OWN_FLAGS,
        OWN_D,
        OWN_SUM_HI,
        OWN_SUM_LO
    } owner_t;

    // Decoded bus access for one cycle
    typedef struct packed {
        logic wr_idx;
        logic wr_dat;
        logic rd_idx;
        logic rd_dat;
    } bus_req_t;

    // Map an index to the logic that serves it
    function automatic owner_t owner_of(input logic [IDX_W-1:0] ix);
        owner_t o;
        case (ix)
            IX_CTL_A:  o = OWN_A;
            IX_CTL_B:  o = OWN_B;
            IX_FLAGS:  o = OWN_FLAGS;
            IX_STAT_D: o = OWN_D;
            IX_SUM_HI: o = OWN_SUM_HI;
            IX_SUM_LO: o = OWN_SUM_LO;
            default:   o = OWN_MEM;
        endcase
        return o;
    endfunction

    // Decode the strobes: a write takes priority over a read
    function automatic bus_req_t decode_bus(input logic sel, input logic rd, input logic wr);
        bus_req_t r;
        r.wr_idx = wr & ~sel;
        r.wr_dat = wr & sel;
        r.rd_idx = rd & ~wr & ~sel;
        r.rd_dat = rd & ~wr & sel;
        return r;
    endfunction

endpackage

// File: rtl/rtc_ctl_regs.sv
// Control and status bytes A, B, flags (C) and D with their access side effects.
// Assumes that the strobes are already qualified by the index, and that at
// most one write strobe is active in a cycle.
module rtc_ctl_regs
    import rtc_regfile_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cold_rst,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic          rd_flags,
    input  logic [DW-1:0] wdata,
    input  logic          upd_busy,
    input  logic          evt_periodic,
    input  logic          evt_alarm,
    input  logic          evt_update,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_b,
    output logic [DW-1:0] reg_flags,
    output logic [DW-1:0] reg_d,
    output logic          irq_clr
);

    logic [DW-2:0] a_low;
    logic          busy_q;
    logic [DW-1:0] b_q;
    logic [DW-1:0] flags_q;
    logic [DW-1:0] d_q;
    logic [DW-1:0] b_wr_val;
    logic [DW-1:0] flags_set;
    logic [DW-1:0] flags_next;
    logic          clr_q;

    // Filter the value written to control B
    always_comb begin
        b_wr_val    = wdata;
        b_wr_val[3] = 1'b0;
        if (wdata[7]) begin
            b_wr_val[4] = 1'b0;
        end
    end

    // Work out the flag bits that enabled events raise
    always_comb begin
        flags_set    = '0;
        flags_set[6] = evt_periodic & b_q[6];
        flags_set[5] = evt_alarm    & b_q[5];
        flags_set[4] = evt_update   & b_q[4];
        flags_set[7] = |flags_set[6:4];
        flags_next   = (rd_flags ? '0 : flags_q) | flags_set;
    end

    // Control A: software writes the low seven bits, the busy flag follows its input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (cold_rst) begin
                a_low  <= COLD_A[DW-2:0];
                busy_q <= 1'b0;
            end
        end else begin
            busy_q <= upd_busy;
            if (wr_a) begin
                a_low <= wdata[DW-2:0];
            end
        end
    end

    // Control B: filtered writes; a warm reset clears the interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= cold_rst ? COLD_B : (b_q & WARM_B_KEEP);
        end else if (wr_b) begin
            b_q <= b_wr_val;
        end
    end

    // Flag byte: set by events, cleared by a read, never written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_next;
        end
    end

    // Status D: loaded only by a cold reset
    always_ff @(posedge clk) begin
        if (!rst_n && cold_rst) begin
            d_q <= COLD_D;
        end
    end

    // Clear pulse, aligned with the registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= rd_flags;
        end
    end

    assign reg_a     = {busy_q, a_low};
    assign reg_b     = b_q;
    assign reg_flags = flags_q;
    assign reg_d     = d_q;
    assign irq_clr   = clr_q;

endmodule

// File: rtl/rtc_byte_store.sv
// General-purpose byte storage, with the century mirror and a packed view of
// the summed range. Assumes that the write strobe already excludes the
// indices owned by the control and checksum logic.
module rtc_byte_store
    import rtc_regfile_pkg::*;
#(
    parameter int N_BYTES  = NREG,
    parameter int AW       = IDX_W,
    parameter int VIEW_LO  = int'(IX_SUM_FIRST),
    parameter int VIEW_N   = SUM_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cold_rst,
    input  logic                 we,
    input  logic [AW-1:0]        idx,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rd_byte,
    output logic [VIEW_N*DW-1:0] view_bytes
);

    logic [DW-1:0] mem [N_BYTES];

    // Byte writes; a write to the alternate century byte also lands on the primary one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (cold_rst) begin
                for (int i = 0; i < N_BYTES; i++) begin
                    mem[i] <= '0;
                end
            end
        end else if (we) begin
            mem[idx] <= wdata;
            if (idx == IX_CENT_ALT) begin
                mem[IX_CENT] <= wdata;
            end
        end
    end

    // Read port for the data-port mux
    assign rd_byte = mem[idx];

    // Flatten the summed range for the checksum adder
    for (genvar g = 0; g < VIEW_N; g++) begin : g_view
        assign view_bytes[g*DW +: DW] = mem[VIEW_LO + g];
    end

endmodule

// File: rtl/rtc_cfg_sum.sv
// Combinational 16-bit sum of a packed byte range.
// Assumes that the sum width is wider than one byte.
module rtc_cfg_sum
    import rtc_regfile_pkg::*;
#(
    parameter int N  = SUM_N,
    parameter int SW = SUM_W
) (
    input  logic [N*DW-1:0] bytes_in,
    output logic [SW-1:0]   sum
);

    logic [SW-1:0] acc;

    // Add the bytes, each zero-extended to the sum width
    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + {{(SW-DW){1'b0}}, bytes_in[i*DW +: DW]};
        end
    end

    assign sum = acc;

endmodule

// File: rtl/rtc_regfile.sv
// Top of the indexed RTC register file: the index register, the access
// decode, the read mux and the registered read data.
// Assumes single-cycle strobes that are sampled on the rising clock edge.
module rtc_regfile
    import rtc_regfile_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cold_rst,
    input  logic          bus_sel,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          upd_busy,
    input  logic          evt_periodic,
    input  logic          evt_alarm,
    input  logic          evt_update,
    output logic          irq,
    output logic          irq_clr,
    output logic [3:0]    rate_sel,
    output logic [2:0]    div_ctl,
    output logic          dst_en,
    output logic          hour24,
    output logic          bin_mode,
    output logic          upd_ie,
    output logic          alm_ie,
    output logic          per_ie,
    output logic          set_mode
);

    bus_req_t         req;
    owner_t           own;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    reg_a, reg_b, reg_flags, reg_d;
    logic [DW-1:0]    mem_byte;
    logic [DW-1:0]    rd_mux;
    logic [DW-1:0]    rdata_q;
    logic [SUM_N*DW-1:0] sum_view;
    logic [SUM_W-1:0] cfg_sum;

    // Decode the strobes and the owner of the current index
    always_comb begin
        req = decode_bus(bus_sel, bus_rd, bus_wr);
        own = owner_of(idx_q);
    end

    // Index register: keeps the low seven bits of an index-port write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (req.wr_idx) begin
            idx_q <= bus_wdata[IDX_W-1:0];
        end
    end

    rtc_ctl_regs u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cold_rst     (cold_rst),
        .wr_a         (req.wr_dat && own == OWN_A),
        .wr_b         (req.wr_dat && own == OWN_B),
        .rd_flags     (req.rd_dat && own == OWN_FLAGS),
        .wdata        (bus_wdata),
        .upd_busy     (upd_busy),
        .evt_periodic (evt_periodic),
        .evt_alarm    (evt_alarm),
        .evt_update   (evt_update),
        .reg_a        (reg_a),
        .reg_b        (reg_b),
        .reg_flags    (reg_flags),
        .reg_d        (reg_d),
        .irq_clr      (irq_clr)
    );

    rtc_byte_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cold_rst   (cold_rst),
        .we         (req.wr_dat && own == OWN_MEM),
        .idx        (idx_q),
        .wdata      (bus_wdata),
        .rd_byte    (mem_byte),
        .view_bytes (sum_view)
    );

    rtc_cfg_sum u_sum (
        .bytes_in (sum_view),
        .sum      (cfg_sum)
    );

    // Pick the byte that a data read of the current index returns
    always_comb begin
        case (own)
            OWN_A:      rd_mux = reg_a;
            OWN_B:      rd_mux = reg_b;
            OWN_FLAGS:  rd_mux = reg_flags;
            OWN_D:      rd_mux = reg_d;
            OWN_SUM_HI: rd_mux = cfg_sum[SUM_W-1:DW];
            OWN_SUM_LO: rd_mux = cfg_sum[DW-1:0];
            default:    rd_mux = mem_byte;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (req.rd_idx) begin
            rdata_q <= '1;
        end else if (req.rd_dat) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = reg_flags[7];
    assign rate_sel  = reg_a[3:0];
    assign div_ctl   = reg_a[6:4];
    assign dst_en    = reg_b[0];
    assign hour24    = reg_b[1];
    assign bin_mode  = reg_b[2];
    assign upd_ie    = reg_b[4];
    assign alm_ie    = reg_b[5];
    assign per_ie    = reg_b[6];
    assign set_mode  = reg_b[7];

endmodule

// File: rtl/rtc_regfile_chk.sv
// Protocol checker for rtc_regfile, attached to it through bind.
// Assumes the synchronous active-low reset of the block it watches.
module rtc_regfile_chk
    import rtc_regfile_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [DW-1:0]    bus_rdata,
    input logic             evt_periodic,
    input logic             evt_alarm,
    input logic             evt_update,
    input logic             irq,
    input logic             irq_clr,
    input logic             set_mode,
    input logic             upd_ie,
    input logic [IDX_W-1:0] idx,
    input logic [DW-1:0]    reg_d
);

    logic rd_only;
    logic rd_flags;
    logic any_evt;

    // Cycle qualifiers shared by the properties
    always_comb begin
        rd_only  = bus_rd && !bus_wr;
        rd_flags = rd_only && bus_sel && idx == IX_FLAGS;
        any_evt  = evt_periodic || evt_alarm || evt_update;
    end

    // R2: an index-port read returns all ones
    p_idx_read_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && !bus_sel) |=> bus_rdata == 8'hFF);

    // R3: a flag read without an event drops the request and pulses the clear
    p_flag_read_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !any_evt) |=> (irq_clr && !irq));

    // R3: the clear pulse only follows a flag read
    p_clr_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |-> $past(rd_flags));

    // R5: writes to status D leave it unchanged
    p_d_readonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && idx == IX_STAT_D) |=> $stable(reg_d));

    // R7: freeze mode and the update-ended enable never coexist
    p_set_blocks_uie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_mode && upd_ie));

    // R7: control B never reads back with bit 3 set
    p_b_bit3_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && bus_sel && idx == IX_CTL_B) |=> !bus_rdata[3]);

    // R12: read data holds when no read is taken
    p_rdata_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_only |=> $stable(bus_rdata));

endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .irq          (irq),
    .irq_clr      (irq_clr),
    .set_mode     (set_mode),
    .upd_ie       (upd_ie),
    .idx          (idx_q),
    .reg_d        (reg_d)
);

// File: tb/rtc_regfile_test.sv
// Scoreboard bench for rtc_regfile. The driver tasks queue the expected read
// data; a monitor pops the queue and compares one time unit after each edge
// that takes a read.
module rtc_regfile_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cold_rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       upd_busy = 1'b0;
    logic       evt_periodic = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_update = 1'b0;
    logic       irq, irq_clr;
    logic [3:0] rate_sel;
    logic [2:0] div_ctl;
    logic       dst_en, hour24, bin_mode, upd_ie, alm_ie, per_ie, set_mode;

    always #10 clk = ~clk;

    rtc_regfile uut (
        .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_busy(upd_busy), .evt_periodic(evt_periodic),
        .evt_alarm(evt_alarm), .evt_update(evt_update),
        .irq(irq), .irq_clr(irq_clr), .rate_sel(rate_sel), .div_ctl(div_ctl),
        .dst_en(dst_en), .hour24(hour24), .bin_mode(bin_mode),
        .upd_ie(upd_ie), .alm_ie(alm_ie), .per_ie(per_ie), .set_mode(set_mode)
    );

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic rd_mark = 1'b0;
    logic done = 1'b0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    // Monitor: compare the registered read data after each edge that took a read
    always @(posedge clk) begin : mon
        exp_t e;
        if (rd_mark) begin
            #1;
            if (sb_q.size() == 0) begin
                chk("R12 unexpected read data", bus_rdata, 8'hxx);
            end else begin
                e = sb_q.pop_front();
                chk(e.tag, bus_rdata, e.val);
            end
        end
    end

    task automatic bus_cycle(input logic sel, input logic rd, input logic wr, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = rd; bus_wr = wr; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic set_idx(input logic [7:0] v);
        bus_cycle(1'b0, 1'b0, 1'b1, v);
    endtask

    task automatic put(input logic [7:0] v);
        bus_cycle(1'b1, 1'b0, 1'b1, v);
    endtask

    task automatic wreg(input logic [7:0] ix, input logic [7:0] v);
        set_idx(ix);
        put(v);
    endtask

    task automatic expect_rd(input logic sel, input logic [7:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        bus_sel = sel; bus_rd = 1'b1; rd_mark = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; rd_mark = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] ix, input logic [7:0] exp, input string tag);
        set_idx(ix);
        expect_rd(1'b1, exp, tag);
    endtask

    // Read the flag byte and check the clear pulse and the request after it
    task automatic rd_flags_chk(input logic [7:0] exp, input logic irq_after, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        set_idx(8'h0C);
        @(negedge clk);
        sb_q.push_back(e);
        bus_sel = 1'b1; bus_rd = 1'b1; rd_mark = 1'b1;
        @(posedge clk);
        #2;
        chk({tag, " irq_clr"}, {7'd0, irq_clr}, 8'h01);
        chk({tag, " irq"}, {7'd0, irq}, {7'd0, irq_after});
        @(negedge clk);
        bus_rd = 1'b0; rd_mark = 1'b0;
    endtask

    task automatic pulse(input logic p, input logic a, input logic u);
        @(negedge clk);
        evt_periodic = p; evt_alarm = a; evt_update = u;
        @(negedge clk);
        evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
    endtask

    task automatic do_reset(input logic cold);
        @(negedge clk);
        rst_n = 1'b0; cold_rst = cold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; cold_rst = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    logic [7:0] held;

    initial begin
        do_reset(1'b1);
        // R10 cold defaults seen on the field ports
        chk("R10 rate_sel", {4'd0, rate_sel}, 8'h06);
        chk("R10 div_ctl", {5'd0, div_ctl}, 8'h02);
        chk("R10 hour24", {7'd0, hour24}, 8'h01);
        chk("R10 irq", {7'd0, irq}, 8'h00);
        chk("R12 rdata after reset", bus_rdata, 8'h00);
        rreg(8'h0A, 8'h26, "R10 ctl A");
        rreg(8'h0B, 8'h02, "R10 ctl B");
        rreg(8'h0C, 8'h00, "R10 flags");
        rreg(8'h0D, 8'h80, "R10 stat D");
        rreg(8'h10, 8'h00, "R10 general byte");
        rreg(8'h2E, 8'h00, "R11 sum high cold");

        // R2 index-port read
        expect_rd(1'b0, 8'hFF, "R2 index read");

        // R1 index keeps seven bits
        set_idx(8'h85);
        put(8'h5A);
        rreg(8'h05, 8'h5A, "R1 index bit7 dropped on write");
        set_idx(8'h85);
        expect_rd(1'b1, 8'h5A, "R1 index bit7 dropped on read");

        // R6 control A low bits, busy flag from input; R13 fields
        wreg(8'h0A, 8'hFB);
        rreg(8'h0A, 8'h7B, "R6 ctl A bit7 not written");
        chk("R13 rate_sel", {4'd0, rate_sel}, 8'h0B);
        chk("R13 div_ctl", {5'd0, div_ctl}, 8'h07);
        upd_busy = 1'b1;
        rreg(8'h0A, 8'hFB, "R6 busy reads back");
        put(8'h26);
        expect_rd(1'b1, 8'hA6, "R6 write keeps busy bit");
        upd_busy = 1'b0;
        rreg(8'h0A, 8'h26, "R6 busy cleared");

        // R7 control B filtering; R13 fields
        wreg(8'h0B, 8'h1E);
        rreg(8'h0B, 8'h16, "R7 bit3 cleared");
        chk("R13 upd_ie", {7'd0, upd_ie}, 8'h01);
        chk("R13 bin_mode", {7'd0, bin_mode}, 8'h01);
        wreg(8'h0B, 8'h9F);
        rreg(8'h0B, 8'h87, "R7 set mode clears bit4");
        chk("R13 set_mode", {7'd0, set_mode}, 8'h01);
        chk("R13 dst_en", {7'd0, dst_en}, 8'h01);
        chk("R7 upd_ie forced low", {7'd0, upd_ie}, 8'h00);

        // R8 century mirror
        wreg(8'h37, 8'h20);
        rreg(8'h32, 8'h20, "R8 mirror to primary");
        rreg(8'h37, 8'h20, "R8 alternate stored");
        wreg(8'h32, 8'h19);
        rreg(8'h37, 8'h20, "R8 primary write not mirrored back");
        rreg(8'h32, 8'h19, "R8 primary written");

        // R11 checksum over 0x10..0x2D
        wreg(8'h10, 8'hFF);
        wreg(8'h2D, 8'hFF);
        wreg(8'h20, 8'h03);
        wreg(8'h0F, 8'h77);
        rreg(8'h2E, 8'h02, "R11 sum high");
        rreg(8'h2F, 8'h01, "R11 sum low");
        put(8'h55);
        expect_rd(1'b1, 8'h01, "R11 sum low ignores write");

        // R4 events gated by enables; R3 clear on read
        pulse(1'b1, 1'b1, 1'b1);
        rreg(8'h0C, 8'h00, "R4 disabled events ignored");
        wreg(8'h0B, 8'h70);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R4 irq raised", {7'd0, irq}, 8'h01);
        rd_flags_chk(8'hC0, 1'b0, "R3 periodic flag read");
        rreg(8'h0C, 8'h00, "R3 flags cleared by read");
        pulse(1'b0, 1'b1, 1'b1);
        rd_flags_chk(8'hB0, 1'b0, "R4 alarm and update flags");
        wreg(8'h0B, 8'h40);
        pulse(1'b0, 1'b1, 1'b0);
        rreg(8'h0C, 8'h00, "R4 alarm masked");

        // R5 read-only status bytes
        pulse(1'b1, 1'b0, 1'b0);
        wreg(8'h0C, 8'h00);
        chk("R5 flag write ignored irq", {7'd0, irq}, 8'h01);
        rd_flags_chk(8'hC0, 1'b0, "R5 flags unchanged by write");
        wreg(8'h0D, 8'h00);
        rreg(8'h0D, 8'h80, "R5 stat D unchanged by write");

        // R4/R3 event in the same cycle as the flag read
        pulse(1'b1, 1'b0, 1'b0);
        set_idx(8'h0C);
        begin : same_cycle
            exp_t e;
            e.val = 8'hC0; e.tag = "R4 read with concurrent event";
            @(negedge clk);
            sb_q.push_back(e);
            bus_sel = 1'b1; bus_rd = 1'b1; rd_mark = 1'b1; evt_periodic = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0; rd_mark = 1'b0; evt_periodic = 1'b0;
        end
        chk("R4 concurrent event keeps irq", {7'd0, irq}, 8'h01);
        expect_rd(1'b1, 8'hC0, "R4 concurrent event flag kept");
        expect_rd(1'b1, 8'h00, "R3 flags clear after second read");

        // R12 read and write together act as a write
        pulse(1'b1, 1'b0, 1'b0);
        held = bus_rdata;
        bus_cycle(1'b1, 1'b1, 1'b1, 8'h00);
        chk("R12 rdata holds on rd+wr", bus_rdata, held);
        chk("R12 rd+wr no clear", {7'd0, irq}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R12 rdata holds idle", bus_rdata, held);
        expect_rd(1'b1, 8'hC0, "R12 flags survive rd+wr");
        bus_cycle(1'b0, 1'b1, 1'b1, 8'h0D);
        expect_rd(1'b1, 8'h80, "R12 rd+wr on index port writes index");

        // R9 warm reset
        wreg(8'h0B, 8'hF7);
        pulse(1'b1, 1'b0, 1'b0);
        wreg(8'h0A, 8'h2B);
        wreg(8'h00, 8'h44);
        set_idx(8'h33);
        do_reset(1'b0);
        chk("R9 irq cleared", {7'd0, irq}, 8'h00);
        chk("R9 rate_sel kept", {4'd0, rate_sel}, 8'h0B);
        chk("R9 per_ie cleared", {7'd0, per_ie}, 8'h00);
        chk("R9 alm_ie cleared", {7'd0, alm_ie}, 8'h00);
        chk("R9 set_mode kept", {7'd0, set_mode}, 8'h01);
        expect_rd(1'b1, 8'h44, "R9 index reset to zero");
        rreg(8'h0B, 8'h87, "R9 ctl B masked");
        rreg(8'h0C, 8'h00, "R9 flags cleared");
        rreg(8'h0D, 8'h80, "R9 stat D kept");
        rreg(8'h0A, 8'h2B, "R9 ctl A kept");
        rreg(8'h05, 8'h5A, "R9 general byte kept");
        rreg(8'h2F, 8'h01, "R9 sum kept");

        // R10 cold reset again
        do_reset(1'b1);
        rreg(8'h0A, 8'h26, "R10 ctl A after cold");
        rreg(8'h05, 8'h00, "R10 general byte cleared");
        rreg(8'h2F, 8'h00, "R10 sum cleared");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            chk("R12 missing read data", 8'(sb_q.size()), 8'h00);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule